// File: doc/BRIEF.md
# PLL Feedback Multiplier Code Converter

This block translates a PLL feedback multiplier between its plain binary value and the scrambled 17-bit code that the PLL's divider register holds. In encode mode it takes a multiplier, walks a 15-bit shift-register sequence from a fixed seed to the matching state, and returns a 32-bit register word. That word holds the code together with the two loop-bandwidth fields (proportional and integral gain) derived from the multiplier. In decode mode it takes a code and walks the sequence the other way, counting steps until it reaches the seed, and so recovers the multiplier. The decoder then rebuilds the same register word from the recovered value.

Requests enter through a valid/ready port and results leave through a second valid/ready port. The block takes one request at a time. It raises `in_ready` only when it is idle, or when its held result is being taken in that same cycle. A result stays on the output, unchanged, for as long as `out_ready` is low. While the block iterates it raises `busy`. A walk can last up to about 32770 cycles, and the output port shows nothing during that time. The multipliers 1 and 2 and their codes bypass the walk and produce a result in the cycle after they are accepted.

Top module: `mcode_codec`

## Requirements
- R1: `in_ready` is high only when no walk is running and either no result is held or `out_ready` is high. A held result keeps `out_valid` high, with `out_msel` and `out_word` stable, until a cycle in which `out_ready` is high.
- R2: When `in_decode`=0, `in_value[15:0]` is the multiplier. A multiplier of 1 returns code 0x18003 and a multiplier of 2 returns code 0x10003. Neither raises `busy`, and `out_valid` is high in the cycle after acceptance.
- R3: For a multiplier m in 3..32768, the code is a 15-bit state x, zero-extended to 17 bits. The walk starts at x=0x4000 and applies (32769-m) steps of x := {x[0]^x[1], x[14:1]}.
- R4: Encoding a multiplier of 0 or one above 32768 returns `out_msel`=0 and `out_word`=0. Any result with `out_msel`=0 has `out_word`=0.
- R5: When `in_decode`=1, `in_value` is the code. Code 0x18003 decodes to 1 and code 0x10003 decodes to 2.
- R6: Any other code is decoded as follows. x is set to bits 14:0 of the code, so bits 16:15 are ignored, and a count is set to 32769. While x differs from 0x4000 and the count is nonzero, x := {x[13:0], x[0]^x[14]} and the count decrements. The final count is the multiplier. A count above 32768 is reported as 0. The code field of the word holds the code as given.
- R7: A code whose walk never reaches 0x4000 (for example 0) decodes to 0, with `out_word`=0.
- R8: For a nonzero multiplier, the word has the code in bits 16:0, the proportional field in bits 21:17 and the integral field in bits 27:22. Bits 31:28 are zero. `out_msel` carries the multiplier.
- R9: The proportional field is (m>>1)+1 for m below 60 and 31 for m of 60 or more.
- R10: The integral field is 1 for m above 16384, 2 for m in 8193..16384, 4 for m in 2049..8192, and 8 for m in 501..2048.
- R11: For m in 60..500, let t=1024/(m+9) by integer division. The integral field is 4t when t*(m+9)=1024 and 4(t+1) otherwise. Below 60 it is (m & 0x3C)+4.
- R12: After reset, `out_valid`=0, `busy`=0 and `in_ready`=1. `busy` is high exactly while a walk runs, from the cycle after acceptance until the result appears. `busy` and `out_valid` are never high together.
- R13: In a cycle where a held result is taken and a new request is offered, the new request is accepted. Its result follows without losing either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_decode | input | 1 | 0 = encode a multiplier, 1 = decode a code |
| in_value | input | 17 | Multiplier in bits 15:0 (encode) or full code (decode) |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_msel | output | 16 | Multiplier of the result, 0 when invalid |
| out_word | output | 32 | Packed divider-register word |
| busy | output | 1 | Walk in progress |

## Verification
The request port and the result port can both complete a transfer in the same clock cycle. The consumer takes a pending result while the producer offers the next request. The bench provokes this by parking a finished result with `out_ready` low. At a single falling edge it then raises `out_ready` together with `in_valid` for a one-cycle request. The case is judged correct if, one cycle later, the new result is on the output with its own multiplier and word, and the old result was seen intact before it.

// File: rtl/mcode_pkg.sv
package mcode_pkg;
  localparam int unsigned MSEL_W   = 16;
  localparam int unsigned CODE_W   = 17;
  localparam int unsigned LFSR_W   = 15;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SELP_W   = 5;
  localparam int unsigned SELI_W   = 6;
  localparam int unsigned SELP_LSB = 17;
  localparam int unsigned SELI_LSB = 22;

  localparam logic [LFSR_W-1:0] SEED     = 15'h4000;
  localparam logic [CODE_W-1:0] CODE_ONE = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_TWO = 17'h10003;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} walk_st_e;

  // one step toward larger step counts (used when building a code)
  function automatic logic [LFSR_W-1:0] fwd_step(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[1], s[LFSR_W-1:1]};
  endfunction

  // inverse step (used when recovering a multiplier)
  function automatic logic [LFSR_W-1:0] back_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[0] ^ s[LFSR_W-1]};
  endfunction
endpackage

// File: rtl/mcode_bandwidth.sv
module mcode_bandwidth
  import mcode_pkg::*;
(
  input  logic [MSEL_W-1:0] msel,
  output logic [SELP_W-1:0] selp,
  output logic [SELI_W-1:0] seli
);
  localparam int unsigned DW = MSEL_W + 1;

  logic [DW-1:0] dvs;
  logic [DW-1:0] quo;
  logic [DW-1:0] prod;
  logic          exact;

  always_comb begin
    dvs   = {1'b0, msel} + DW'(9);
    quo   = DW'(1024) / dvs;
    prod  = quo * dvs;
    exact = (prod == DW'(1024));
  end

  always_comb begin
    if (msel < MSEL_W'(60)) selp = SELP_W'(msel[SELP_W:1]) + SELP_W'(1);
    else                    selp = SELP_W'(31);
  end

  always_comb begin
    if      (msel > MSEL_W'(16384)) seli = SELI_W'(1);
    else if (msel > MSEL_W'(8192))  seli = SELI_W'(2);
    else if (msel > MSEL_W'(2048))  seli = SELI_W'(4);
    else if (msel >= MSEL_W'(501))  seli = SELI_W'(8);
    else if (msel >= MSEL_W'(60))   seli = exact ? SELI_W'({quo[3:0], 2'b00})
                                                 : SELI_W'({quo[3:0] + 4'd1, 2'b00});
    else                            seli = {msel[5:2], 2'b00} + SELI_W'(4);
  end
endmodule

// File: rtl/mcode_engine.sv
module mcode_engine
  import mcode_pkg::*;
#(
  parameter int unsigned MAX_MSEL = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_decode,
  input  logic [CODE_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              busy,
  output logic [MSEL_W-1:0] res_msel,
  output logic [CODE_W-1:0] res_code
);
  localparam logic [MSEL_W-1:0] MAX_V   = MSEL_W'(MAX_MSEL);
  localparam logic [MSEL_W-1:0] CNT_TOP = MSEL_W'(MAX_MSEL + 1);

  walk_st_e          st;
  logic              is_dec;
  logic [LFSR_W-1:0] x;
  logic [MSEL_W-1:0] cnt;
  logic [MSEL_W-1:0] enc_m;
  logic              accept;

  assign enc_m     = in_value[MSEL_W-1:0];
  assign in_ready  = (st == ST_IDLE) || (st == ST_HOLD && out_ready);
  assign accept    = in_valid && in_ready;
  assign out_valid = (st == ST_HOLD);
  assign busy      = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      is_dec   <= 1'b0;
      x        <= '0;
      cnt      <= '0;
      res_msel <= '0;
      res_code <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            is_dec <= in_decode;
            if (in_decode) begin
              res_code <= in_value;
              if (in_value == CODE_ONE) begin
                res_msel <= MSEL_W'(1);
                st       <= ST_HOLD;
              end else if (in_value == CODE_TWO) begin
                res_msel <= MSEL_W'(2);
                st       <= ST_HOLD;
              end else begin
                res_msel <= '0;
                x        <= in_value[LFSR_W-1:0];
                cnt      <= CNT_TOP;
                st       <= ST_RUN;
              end
            end else begin
              if (enc_m == '0 || enc_m > MAX_V) begin
                res_msel <= '0;
                res_code <= '0;
                st       <= ST_HOLD;
              end else if (enc_m == MSEL_W'(1)) begin
                res_msel <= enc_m;
                res_code <= CODE_ONE;
                st       <= ST_HOLD;
              end else if (enc_m == MSEL_W'(2)) begin
                res_msel <= enc_m;
                res_code <= CODE_TWO;
                st       <= ST_HOLD;
              end else begin
                res_msel <= enc_m;
                res_code <= '0;
                x        <= SEED;
                cnt      <= CNT_TOP - enc_m;
                st       <= ST_RUN;
              end
            end
          end else if (st == ST_HOLD && out_ready) begin
            st <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (!is_dec) begin
            if (cnt == '0) begin
              res_code <= CODE_W'(x);
              st       <= ST_HOLD;
            end else begin
              x   <= fwd_step(x);
              cnt <= cnt - MSEL_W'(1);
            end
          end else begin
            if (x == SEED || cnt == '0) begin
              res_msel <= (cnt > MAX_V) ? '0 : cnt;
              st       <= ST_HOLD;
            end else begin
              x   <= back_step(x);
              cnt <= cnt - MSEL_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcode_codec.sv
module mcode_codec
  import mcode_pkg::*;
#(
  parameter int unsigned MAX_MSEL = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_decode,
  input  logic [CODE_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MSEL_W-1:0] out_msel,
  output logic [WORD_W-1:0] out_word,
  output logic              busy
);
  logic [CODE_W-1:0] res_code;
  logic [SELP_W-1:0] selp;
  logic [SELI_W-1:0] seli;

  mcode_engine #(.MAX_MSEL(MAX_MSEL)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_decode (in_decode),
    .in_value  (in_value),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .busy      (busy),
    .res_msel  (out_msel),
    .res_code  (res_code)
  );

  mcode_bandwidth u_bw (
    .msel (out_msel),
    .selp (selp),
    .seli (seli)
  );

  always_comb begin
    out_word = '0;
    if (out_msel != '0) begin
      out_word[CODE_W-1:0]          = res_code;
      out_word[SELP_LSB +: SELP_W]  = selp;
      out_word[SELI_LSB +: SELI_W]  = seli;
    end
  end
endmodule

// File: rtl/mcode_codec_chk.sv
module mcode_codec_chk
  import mcode_pkg::*;
#(
  parameter int unsigned MAX_MSEL = 32768
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              busy,
  input logic [MSEL_W-1:0] out_msel,
  input logic [WORD_W-1:0] out_word
);
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_msel));

  a_r1_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy && (!out_valid || out_ready));

  a_r12_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);

  a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_msel <= MSEL_W'(MAX_MSEL));

  a_r4_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_msel == '0 |-> out_word == '0);

  a_r8_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[WORD_W-1:SELI_LSB+SELI_W] == '0);

  a_r9_selp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_msel >= MSEL_W'(60) |-> out_word[SELP_LSB +: SELP_W] == SELP_W'(31));

  a_r10_seli_top: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_msel > MSEL_W'(16384) |-> out_word[SELI_LSB +: SELI_W] == SELI_W'(1));
endmodule

bind mcode_codec mcode_codec_chk #(.MAX_MSEL(MAX_MSEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .busy      (busy),
  .out_msel  (out_msel),
  .out_word  (out_word)
);

// File: tb/mcode_codec_tb.sv
module mcode_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;
  localparam int NVEC       = 13;
  // bit 17 = decode flag, bits 16:0 = value
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 17'd1},     {1'b0, 17'd2},     {1'b0, 17'd32768},
    {1'b0, 17'd32767}, {1'b0, 17'd32000}, {1'b0, 17'd30000},
    {1'b0, 17'd0},     {1'b0, 17'd40000}, {1'b1, 17'h18003},
    {1'b1, 17'h10003}, {1'b1, 17'h04000}, {1'b1, 17'h02000},
    {1'b1, 17'h1A000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_decode = 1'b0;
  logic [16:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_msel;
  logic [31:0] out_word;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcode_codec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decode(in_decode), .in_value(in_value), .out_valid(out_valid),
    .out_ready(out_ready), .out_msel(out_msel), .out_word(out_word), .busy(busy)
  );

  // ---- reference model from the requirements ----
  function automatic int m_enc(input int m);
    int x;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = 0; i < 32769 - m; i++)
      x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hFFFF);
    return x;
  endfunction

  function automatic int m_dec(input int code);
    int x, n;
    if (code == 'h18003) return 1;
    if (code == 'h10003) return 2;
    x = code & 'h7FFF;
    n = 32769;
    while (x != 'h4000 && n > 0) begin
      x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7FFF);
      n--;
    end
    return (n > 32768) ? 0 : n;
  endfunction

  function automatic int m_selp(input int m);
    return (m < 60) ? (m >> 1) + 1 : 31;
  endfunction

  function automatic int m_seli(input int m);
    int t;
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60) begin
      t = 1024 / (m + 9);
      return (t * (m + 9) == 1024) ? 4 * t : 4 * (t + 1);
    end
    return (m & 'h3C) + 4;
  endfunction

  function automatic logic [31:0] m_word(input int m, input int code);
    if (m == 0) return 32'h0;
    return 32'((m_seli(m) << 22) | (m_selp(m) << 17) | code);
  endfunction

  // ---- helpers ----
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic dec, input logic [16:0] val);
    @(negedge clk);
    in_valid = 1'b1; in_decode = dec; in_value = val;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(output logic [15:0] m, output logic [31:0] w);
    while (!out_valid) @(negedge clk);
    m = out_msel; w = out_word;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_enc(input string tag, input int m);
    logic [15:0] am; logic [31:0] aw;
    issue(1'b0, 17'(m));
    collect(am, aw);
    chk({tag, " msel"}, 32'(am), 32'(m));
    chk({tag, " word"}, aw, m_word(m, m_enc(m)));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] am;
    logic [31:0] aw;
    logic [31:0] code32k;
    int em;
    string tag;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset out_valid", 32'(out_valid), 32'd0);
    chk("R12 reset busy", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle in_ready", 32'(in_ready), 32'd1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic        dec;
      int          v;
      dec = VEC[i][17];
      v   = int'(VEC[i][16:0]);
      if (dec) begin
        em  = m_dec(v);
        tag = (v == 'h18003 || v == 'h10003) ? "R5" : "R6";
      end else begin
        em  = (v == 0 || v > 32768) ? 0 : v;
        tag = (em == 0) ? "R4" : ((v <= 2) ? "R2" : "R3");
      end
      issue(dec, 17'(v));
      collect(am, aw);
      chk({tag, " msel"}, 32'(am), 32'(em));
      chk({tag, " word"}, aw, m_word(em, dec ? v : m_enc(em)));
    end

    // R2 special value completes without a walk
    issue(1'b0, 17'd1);
    chk("R2 no busy", 32'(busy), 32'd0);
    chk("R2 immediate valid", 32'(out_valid), 32'd1);
    collect(am, aw);

    // R12 busy during walk, R8 field layout
    issue(1'b0, 17'd32768);
    chk("R12 busy during walk", 32'(busy), 32'd1);
    chk("R12 no valid during walk", 32'(out_valid), 32'd0);
    collect(am, aw);
    chk("R8 code field", 32'(aw[16:0]), 32'(m_enc(32768)));
    chk("R8 selp field", 32'(aw[21:17]), 32'd31);
    chk("R8 seli field", 32'(aw[27:22]), 32'd1);
    chk("R8 upper zero", 32'(aw[31:28]), 32'd0);

    // R1 back-pressure
    issue(1'b0, 17'd32766);
    while (!out_valid) @(negedge clk);
    aw = out_word;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 held valid", 32'(out_valid), 32'd1);
      chk("R1 no ready while held", 32'(in_ready), 32'd0);
      chk("R1 stable word", out_word, aw);
    end
    chk("R1 held word value", aw, m_word(32766, m_enc(32766)));

    // R13 take and accept in one cycle
    out_ready = 1'b1; in_valid = 1'b1; in_decode = 1'b0; in_value = 17'd2;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    chk("R13 new result valid", 32'(out_valid), 32'd1);
    chk("R13 new result msel", 32'(out_msel), 32'd2);
    chk("R13 new result word", out_word, m_word(2, 'h10003));
    collect(am, aw);

    // R6 round trip
    issue(1'b0, 17'd32000);
    collect(am, aw);
    code32k = {15'd0, aw[16:0]};
    issue(1'b1, code32k[16:0]);
    collect(am, aw);
    chk("R6 round trip msel", 32'(am), 32'd32000);

    // R9/R11 low range, R11 exact division, R10 thresholds
    run_enc("R9 R11 msel59", 59);
    run_enc("R11 exact msel119", 119);
    run_enc("R10 msel16385", 16385);
    run_enc("R10 msel16384", 16384);

    // R7 code that never reaches the seed
    issue(1'b1, 17'd0);
    collect(am, aw);
    chk("R7 msel", 32'(am), 32'd0);
    chk("R7 word", aw, 32'd0);

    finish_run();
  end
endmodule